// File: doc/BRIEF.md
# Dual Address Space Bus Cycle Steering

This block sits between a core's single memory request port and two bus handshake sets. One set is the normal address-strobe/ready pair that user memory watches. The other is an alternate pair reserved for a private emulation memory space. The block takes one request at a time and latches its address, direction and write data. It then raises exactly one of the two strobes and holds it until the ready input of that same pair comes back. It also drives one extra address bit above the normal range, which tells external decode logic whether the cycle targets the private space.

While the emulation-mode flag is high, ordinary requests go out on the alternate pair. The normal pair stays quiet, so the user bus looks dormant. A request can carry a user-space override flag. Such a request always uses the normal pair with the extra address bit low, so it reaches user memory even in emulation mode. Outside emulation mode the override flag changes nothing.

The block sends the completion to the core in the same cycle that the selected ready is seen, together with the read data. The mode flag is sampled only while no cycle is outstanding, so a mode change cannot split a handshake.

The controller has three states:
- `ST_IDLE`: no cycle is outstanding, and the block accepts a request.
- `ST_NRM`: the normal strobe is held.
- `ST_ALT`: the alternate strobe is held.

It has these transitions:
- **issue-normal**: `ST_IDLE`→`ST_NRM` on a valid request when the mode is off or the override is set.
- **issue-alternate**: `ST_IDLE`→`ST_ALT` on a valid request in emulation mode without the override.
- **complete-normal**: `ST_NRM`→`ST_IDLE` when the normal ready is high.
- **complete-alternate**: `ST_ALT`→`ST_IDLE` when the alternate ready is high.
- **wait**: every other case holds the current state.

Top module: `dual_space_bus_steer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both strobes are low, `req_ready_o` is high, `rsp_valid_o` is low and `bus_space_o` is low.
- R2: With the mode flag low, a request accepted in `ST_IDLE` raises `nrm_strb_o` in the next cycle, with `bus_space_o` low and `alt_strb_o` low.
- R3: With the mode flag high and the override low at acceptance, the cycle raises `alt_strb_o` with `bus_space_o` high, and `nrm_strb_o` stays low for the whole cycle.
- R4: With the mode flag high and the override high at acceptance, the cycle raises `nrm_strb_o` with `bus_space_o` low.
- R5: With the mode flag low, a request with the override set is handled exactly as one without it: it uses the normal pair, with `bus_space_o` low.
- R6: At most one cycle is outstanding. `req_ready_o` is high only when neither strobe is high, and the two strobes are never high together.
- R7: A raised strobe stays high until its own ready input is sampled high. The ready input of the other pair has no effect on the cycle.
- R8: `rsp_valid_o` is high exactly in the cycle where the active pair's ready is high, and `rsp_rdata_o` then equals `bus_rdata_i`. The block returns to `ST_IDLE` on the next cycle.
- R9: The mode flag is sampled only in `ST_IDLE`. A change during an outstanding cycle does not alter that cycle's strobe or `bus_space_o`. In `ST_IDLE`, `bus_space_o` shows the mode flag sampled on the previous clock.
- R10: During a cycle, `bus_addr_o`, `bus_we_o` and `bus_wdata_o` equal the address, write flag and data presented at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| emu_mode_i | input | 1 | Emulation operating mode flag |
| req_valid_i | input | 1 | Core request valid |
| req_addr_i | input | AW | Request address |
| req_we_i | input | 1 | Request is a write |
| req_wdata_i | input | DW | Request write data |
| req_user_i | input | 1 | Force the user-space (normal) handshake |
| req_ready_o | output | 1 | Request accepted this cycle when valid |
| rsp_valid_o | output | 1 | Cycle completes this cycle |
| rsp_rdata_o | output | DW | Read data returned to the core |
| nrm_strb_o | output | 1 | Normal address strobe |
| nrm_rdy_i | input | 1 | Normal ready |
| alt_strb_o | output | 1 | Alternate address strobe |
| alt_rdy_i | input | 1 | Alternate ready |
| bus_addr_o | output | AW | Latched cycle address |
| bus_space_o | output | 1 | Extra high address bit selecting the private space |
| bus_we_o | output | 1 | Latched write flag |
| bus_wdata_o | output | DW | Latched write data |
| bus_rdata_i | input | DW | Read data from the bus |

## Verification
The bench builds the block with `AW` = 8 and `DW` = 8. With these narrow buses, random addresses and data often reach all-zero and all-ones values, so the payload latch is tested at its extremes. The stimulus toggles the mode flag and the override freely, including in the middle of outstanding cycles. It also raises the other pair's ready on its own. This covers every pairing of mode and override, and it checks that mode changes made during a handshake are deferred.

// File: rtl/dss_pkg.sv
package dss_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_NRM  = 2'd1,
        ST_ALT  = 2'd2
    } steer_st_e;
endpackage

// File: rtl/dss_fsm.sv
module dss_fsm
    import dss_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic emu_mode_i,
    input  logic req_valid_i,
    input  logic req_user_i,
    input  logic nrm_rdy_i,
    input  logic alt_rdy_i,
    output logic capture_o,
    output logic req_ready_o,
    output logic nrm_strb_o,
    output logic alt_strb_o,
    output logic space_o,
    output logic rsp_valid_o
);
    steer_st_e state_q, state_d;
    logic      mode_q;

    // state register; the mode is frozen while a cycle is outstanding
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) begin
                mode_q <= emu_mode_i;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid_i) begin
                    state_d = (emu_mode_i && !req_user_i) ? ST_ALT : ST_NRM;
                end
            end
            ST_NRM: begin
                if (nrm_rdy_i) state_d = ST_IDLE;
            end
            ST_ALT: begin
                if (alt_rdy_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        capture_o   = 1'b0;
        req_ready_o = 1'b0;
        nrm_strb_o  = 1'b0;
        alt_strb_o  = 1'b0;
        space_o     = 1'b0;
        rsp_valid_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready_o = 1'b1;
                capture_o   = req_valid_i;
                space_o     = mode_q;
            end
            ST_NRM: begin
                nrm_strb_o  = 1'b1;
                rsp_valid_o = nrm_rdy_i;
            end
            ST_ALT: begin
                alt_strb_o  = 1'b1;
                space_o     = mode_q;
                rsp_valid_o = alt_rdy_i;
            end
            default: ;
        endcase
    end

    // R7
    nrm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nrm_strb_o && !nrm_rdy_i) |=> nrm_strb_o);
    // R7
    alt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_strb_o && !alt_rdy_i) |=> alt_strb_o);
    // R8
    back_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |=> req_ready_o);
    // R9
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_strb_o && !alt_rdy_i) |=> space_o);
endmodule

// File: rtl/dss_latch.sv
module dss_latch #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture_i,
    input  logic [AW-1:0] addr_i,
    input  logic          we_i,
    input  logic [DW-1:0] wdata_i,
    output logic [AW-1:0] addr_o,
    output logic          we_o,
    output logic [DW-1:0] wdata_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_o  <= '0;
            we_o    <= 1'b0;
            wdata_o <= '0;
        end else if (capture_i) begin
            addr_o  <= addr_i;
            we_o    <= we_i;
            wdata_o <= wdata_i;
        end
    end
endmodule

// File: rtl/dual_space_bus_steer.sv
module dual_space_bus_steer #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          emu_mode_i,
    input  logic          req_valid_i,
    input  logic [AW-1:0] req_addr_i,
    input  logic          req_we_i,
    input  logic [DW-1:0] req_wdata_i,
    input  logic          req_user_i,
    output logic          req_ready_o,
    output logic          rsp_valid_o,
    output logic [DW-1:0] rsp_rdata_o,
    output logic          nrm_strb_o,
    input  logic          nrm_rdy_i,
    output logic          alt_strb_o,
    input  logic          alt_rdy_i,
    output logic [AW-1:0] bus_addr_o,
    output logic          bus_space_o,
    output logic          bus_we_o,
    output logic [DW-1:0] bus_wdata_o,
    input  logic [DW-1:0] bus_rdata_i
);
    logic capture;

    dss_fsm i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .emu_mode_i  (emu_mode_i),
        .req_valid_i (req_valid_i),
        .req_user_i  (req_user_i),
        .nrm_rdy_i   (nrm_rdy_i),
        .alt_rdy_i   (alt_rdy_i),
        .capture_o   (capture),
        .req_ready_o (req_ready_o),
        .nrm_strb_o  (nrm_strb_o),
        .alt_strb_o  (alt_strb_o),
        .space_o     (bus_space_o),
        .rsp_valid_o (rsp_valid_o)
    );

    dss_latch #(.AW(AW), .DW(DW)) i_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture),
        .addr_i    (req_addr_i),
        .we_i      (req_we_i),
        .wdata_i   (req_wdata_i),
        .addr_o    (bus_addr_o),
        .we_o      (bus_we_o),
        .wdata_o   (bus_wdata_o)
    );

    assign rsp_rdata_o = bus_rdata_i;

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nrm_strb_o && alt_strb_o));
    // R6
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nrm_strb_o || alt_strb_o) |-> !req_ready_o);
    // R4
    nrm_space_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nrm_strb_o |-> !bus_space_o);
    // R3
    alt_space_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alt_strb_o |-> bus_space_o);
    // R10
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((nrm_strb_o && !nrm_rdy_i) || (alt_strb_o && !alt_rdy_i))
        |=> ($stable(bus_addr_o) && $stable(bus_wdata_o) && $stable(bus_we_o)));
endmodule

// File: tb/test_dual_space_bus_steer.sv
module test_dual_space_bus_steer;
    localparam int AW = 8;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          emu_mode_i = 1'b0, req_valid_i = 1'b0, req_we_i = 1'b0, req_user_i = 1'b0;
    logic [AW-1:0] req_addr_i = '0;
    logic [DW-1:0] req_wdata_i = '0, bus_rdata_i = '0;
    logic          nrm_rdy_i = 1'b0, alt_rdy_i = 1'b0;
    logic          req_ready_o, rsp_valid_o, nrm_strb_o, alt_strb_o, bus_space_o, bus_we_o;
    logic [DW-1:0] rsp_rdata_o, bus_wdata_o;
    logic [AW-1:0] bus_addr_o;

    int total = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dual_space_bus_steer #(.AW(AW), .DW(DW)) i_dual_space_bus_steer (
        .clk(clk), .rst_n(rst_n), .emu_mode_i(emu_mode_i), .req_valid_i(req_valid_i),
        .req_addr_i(req_addr_i), .req_we_i(req_we_i), .req_wdata_i(req_wdata_i),
        .req_user_i(req_user_i), .req_ready_o(req_ready_o), .rsp_valid_o(rsp_valid_o),
        .rsp_rdata_o(rsp_rdata_o), .nrm_strb_o(nrm_strb_o), .nrm_rdy_i(nrm_rdy_i),
        .alt_strb_o(alt_strb_o), .alt_rdy_i(alt_rdy_i), .bus_addr_o(bus_addr_o),
        .bus_space_o(bus_space_o), .bus_we_o(bus_we_o), .bus_wdata_o(bus_wdata_o),
        .bus_rdata_i(bus_rdata_i)
    );

    // behavioural reference: 0 idle, 1 normal cycle, 2 alternate cycle
    int    m_st = 0;
    bit    m_mode = 0;
    int    m_addr = 0, m_wd = 0;
    bit    m_we = 0;
    string m_tag = "R2";
    bit    m_first = 1;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    task automatic compare();
        string t;
        if (!rst_n || m_first) begin
            t = "R1";
            chk(t, int'(rsp_valid_o), 0);
        end else t = (m_st == 0) ? "R6" : m_tag;
        chk(t, int'(req_ready_o), int'(m_st == 0));
        chk(t, int'(nrm_strb_o), int'(m_st == 1));
        chk(t, int'(alt_strb_o), int'(m_st == 2));
        chk((m_st == 0 && !t.compare("R6")) ? "R9" : t,
            int'(bus_space_o), (m_st == 1) ? 0 : int'(m_mode));
        if (rst_n && m_st != 0) begin
            chk(((m_st == 1 && alt_rdy_i) || (m_st == 2 && nrm_rdy_i)) ? "R7" : "R8",
                int'(rsp_valid_o), int'((m_st == 1 && nrm_rdy_i) || (m_st == 2 && alt_rdy_i)));
            chk("R10", int'(bus_addr_o), m_addr);
            chk("R10", int'(bus_wdata_o), m_wd);
            chk("R10", int'(bus_we_o), int'(m_we));
            if (rsp_valid_o) chk("R8", int'(rsp_rdata_o), int'(bus_rdata_i));
        end else if (rst_n) begin
            chk("R8", int'(rsp_valid_o), 0);
        end
    endtask

    task automatic advance();
        if (!rst_n) begin
            m_st = 0; m_mode = 0; m_first = 1;
            return;
        end
        m_first = 0;
        if (m_st == 0) begin
            m_mode = emu_mode_i;
            if (req_valid_i) begin
                m_st   = (emu_mode_i && !req_user_i) ? 2 : 1;
                m_tag  = emu_mode_i ? (req_user_i ? "R4" : "R3") : (req_user_i ? "R5" : "R2");
                m_addr = int'(req_addr_i);
                m_wd   = int'(req_wdata_i);
                m_we   = req_we_i;
            end
        end else if (m_st == 1 && nrm_rdy_i) m_st = 0;
        else if (m_st == 2 && alt_rdy_i) m_st = 0;
    endtask

    task automatic step(input bit rv, input bit emu, input bit usr, input bit nr, input bit ar);
        @(negedge clk);
        req_valid_i = rv; emu_mode_i = emu; req_user_i = usr;
        nrm_rdy_i = nr; alt_rdy_i = ar;
        req_addr_i = AW'($urandom); req_wdata_i = DW'($urandom);
        req_we_i = 1'($urandom); bus_rdata_i = DW'($urandom);
        #1;
        compare();
        advance();
    endtask

    initial begin
        // R1: reset and first cycle after it
        step(1, 1, 0, 1, 1);
        step(1, 1, 0, 1, 1);
        @(negedge clk); rst_n = 1'b1;
        m_first = 1;
        #1; compare(); advance();
        // R2: normal cycle, alternate ready ignored (R7)
        step(1, 0, 0, 0, 1);
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 1, 0);
        // R3: emulation cycle, then mode drops mid-cycle (R9)
        step(0, 1, 0, 0, 0);
        step(1, 1, 0, 0, 0);
        step(0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1);
        // R4: override in emulation mode
        step(0, 1, 0, 0, 0);
        step(1, 1, 1, 0, 1);
        step(0, 1, 0, 0, 1);
        step(0, 1, 0, 1, 0);
        // R5: override outside emulation mode
        step(1, 0, 1, 0, 0);
        step(0, 1, 0, 1, 0);
        // mixed traffic
        for (int i = 0; i < 3000; i++) begin
            step(1'($urandom_range(0, 1)), ($urandom_range(0, 7) < 4),
                 ($urandom_range(0, 2) == 0), ($urandom_range(0, 2) == 0),
                 ($urandom_range(0, 2) == 0));
        end
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule